// File: doc/BRIEF.md
# Serial Link Training Controller

This block takes a point-to-point serial link from reset to its normal data state. It has no lane logic of its own. A physical-layer model reports what happened on the wire through simple status inputs: a partner was detected, symbol lock was reached, the lanes are aligned, the width was agreed, an error was seen, the partner asked for idle, or a wake was requested. The controller turns these reports into a state sequence. It also drives a training-sequence transmit enable, the current rate generation and a link-up flag.

Training starts only on a rising edge of the active-low fundamental reset input, and only once the reference clock is reported valid. The link then moves through detect, polling and configuration to the active state, always at the first-generation rate. From the active state it can go to recovery, which retrains the link, or to a low-power state. A wake from low power always passes through recovery. Each training state has a timeout. A bounded number of failed recovery attempts sends the link back to detect.

Top module: `link_train_fsm`

## Requirements
- R1: While rst_ni is low, and on the cycle after any cycle in which perst_ni is sampled low, state_o is IDLE (0). After rst_ni, link_up_o, ts_tx_o, rate_o and width_o are all 0.
- R2: Training starts only after a low-to-high transition of perst_ni. A perst_ni that has been high since reset starts nothing. The machine enters DETECT (1) on the first edge at which refclk_ok_i is high once the transition has been seen. This may be the same edge as the transition.
- R3: In DETECT, rx_detect_i moves the state to POLL (2) at the next edge. rate_o is 1 (first generation) in every state except IDLE, where it is 0.
- R4: ts_tx_o is high exactly in POLL, CONFIG and RECOVER. In POLL, sym_lock_i moves the state to CONFIG (3).
- R5: In CONFIG, lane_align_i together with a width_i from 1 to MAX_WIDTH (32) moves the state to ACTIVE (4) and latches width_i and lane_rev_i into width_o and lane_rev_o. An alignment report with a width of 0 or above MAX_WIDTH is ignored.
- R6: DETECT, POLL and CONFIG last at most TMO_CYC (16) cycles without advancing. On expiry, POLL and CONFIG return to DETECT and DETECT restarts itself. If the advance input is present on the expiry edge, the advance wins.
- R7: link_up_o is high exactly while the state is ACTIVE, and it drops on the cycle the state leaves ACTIVE.
- R8: In ACTIVE, err_i moves the state to RECOVER (5). Otherwise idle_req_i moves it to LOWPWR (6). If both are present, err_i wins.
- R9: In RECOVER, sym_lock_i returns the state to ACTIVE. Each TMO_CYC window without lock counts as one failed attempt. After RECOV_TRIES (3) failed attempts, the state goes to DETECT.
- R10: LOWPWR has no timeout. It stays put until wake_i, which moves the state to RECOVER.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| perst_ni | input | 1 | Fundamental link reset, active low; its release starts training |
| refclk_ok_i | input | 1 | Reference clock present |
| rx_detect_i | input | 1 | Link partner detected |
| sym_lock_i | input | 1 | Bit and symbol lock reported |
| lane_align_i | input | 1 | Lane-to-lane alignment done |
| width_i | input | 6 | Negotiated lane count |
| lane_rev_i | input | 1 | Negotiated lane numbering is reversed |
| err_i | input | 1 | Link error seen |
| idle_req_i | input | 1 | Partner requests low power |
| wake_i | input | 1 | Wake request |
| state_o | output | 3 | Current state code |
| rate_o | output | 3 | Current rate generation |
| ts_tx_o | output | 1 | Transmit training sequences |
| link_up_o | output | 1 | Link in active state |
| width_o | output | 6 | Latched lane count |
| lane_rev_o | output | 1 | Latched lane reversal |

## Verification
Two pairs of events can land on the same edge. The first is a state timeout and the input that would advance the state. The bench holds the machine in POLL for exactly TMO_CYC-1 cycles and then raises sym_lock_i, so that lock and expiry meet on one edge. The bench expects CONFIG there, not DETECT. The second pair is err_i and idle_req_i, raised together in ACTIVE. The expected result is RECOVER. The behavioural model settles both cases by its own priority order, independent of the RTL, and is compared with every output on every cycle.

// File: rtl/link_train_pkg.sv
package link_train_pkg;
  typedef enum logic [2:0] {
    LT_IDLE    = 3'd0,
    LT_DETECT  = 3'd1,
    LT_POLL    = 3'd2,
    LT_CONFIG  = 3'd3,
    LT_ACTIVE  = 3'd4,
    LT_RECOVER = 3'd5,
    LT_LOWPWR  = 3'd6
  } lt_state_e;

  localparam logic [2:0] RATE_NONE = 3'd0;
  localparam logic [2:0] RATE_GEN1 = 3'd1;
endpackage

// File: rtl/lt_timer.sv
module lt_timer #(
  parameter int unsigned TMO_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic expired_o
);
  localparam int unsigned TW = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == TW'(TMO_CYC - 1));
endmodule

// File: rtl/lt_retry.sv
module lt_retry #(
  parameter int unsigned TRIES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned CW = (TRIES > 1) ? $clog2(TRIES) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CW'(TRIES - 1));
endmodule

// File: rtl/lt_cfg_latch.sv
module lt_cfg_latch #(
  parameter int unsigned MAX_WIDTH = 32,
  localparam int unsigned WW = $clog2(MAX_WIDTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [WW-1:0] width_i,
  input  logic          rev_i,
  output logic          valid_o,
  output logic [WW-1:0] width_o,
  output logic          rev_o
);
  assign valid_o = (width_i != '0) && (width_i <= WW'(MAX_WIDTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      width_o <= '0;
      rev_o   <= 1'b0;
    end else if (load_i) begin
      width_o <= width_i;
      rev_o   <= rev_i;
    end
  end
endmodule

// File: rtl/link_train_fsm.sv
module link_train_fsm
  import link_train_pkg::*;
#(
  parameter int unsigned TMO_CYC     = 16,
  parameter int unsigned RECOV_TRIES = 3,
  parameter int unsigned MAX_WIDTH   = 32,
  localparam int unsigned WW = $clog2(MAX_WIDTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          perst_ni,
  input  logic          refclk_ok_i,
  input  logic          rx_detect_i,
  input  logic          sym_lock_i,
  input  logic          lane_align_i,
  input  logic [WW-1:0] width_i,
  input  logic          lane_rev_i,
  input  logic          err_i,
  input  logic          idle_req_i,
  input  logic          wake_i,
  output logic [2:0]    state_o,
  output logic [2:0]    rate_o,
  output logic          ts_tx_o,
  output logic          link_up_o,
  output logic [WW-1:0] width_o,
  output logic          lane_rev_o
);
  lt_state_e state_q, state_d;
  logic perst_q, armed_q, armed_d;
  logic perst_rise, expired, retry_last, width_ok;
  logic restart, load_cfg, retry_inc, timed, tmr_clr, retry_clr;

  assign perst_rise = perst_ni & ~perst_q;

  always_comb begin
    state_d   = state_q;
    armed_d   = armed_q;
    restart   = 1'b0;
    load_cfg  = 1'b0;
    retry_inc = 1'b0;
    if (!perst_ni) begin
      state_d = LT_IDLE;
      armed_d = 1'b0;
    end else begin
      unique case (state_q)
        LT_IDLE: begin
          if ((perst_rise || armed_q) && refclk_ok_i) begin
            state_d = LT_DETECT;
            armed_d = 1'b0;
          end else if (perst_rise) begin
            armed_d = 1'b1;
          end
        end
        LT_DETECT: begin
          if (rx_detect_i)  state_d = LT_POLL;
          else if (expired) restart = 1'b1;
        end
        LT_POLL: begin
          if (sym_lock_i)   state_d = LT_CONFIG;
          else if (expired) state_d = LT_DETECT;
        end
        LT_CONFIG: begin
          if (lane_align_i && width_ok) begin
            state_d  = LT_ACTIVE;
            load_cfg = 1'b1;
          end else if (expired) begin
            state_d = LT_DETECT;
          end
        end
        LT_ACTIVE: begin
          if (err_i)           state_d = LT_RECOVER;
          else if (idle_req_i) state_d = LT_LOWPWR;
        end
        LT_RECOVER: begin
          if (sym_lock_i) begin
            state_d = LT_ACTIVE;
          end else if (expired) begin
            if (retry_last) state_d = LT_DETECT;
            else begin
              retry_inc = 1'b1;
              restart   = 1'b1;
            end
          end
        end
        LT_LOWPWR: begin
          if (wake_i) state_d = LT_RECOVER;
        end
        default: state_d = LT_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LT_IDLE;
      perst_q <= 1'b1;  // a level held high since reset is not a release
      armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      perst_q <= perst_ni;
      armed_q <= armed_d;
    end
  end

  assign timed     = (state_q == LT_DETECT) || (state_q == LT_POLL) ||
                     (state_q == LT_CONFIG) || (state_q == LT_RECOVER);
  assign tmr_clr   = (state_d != state_q) || restart || !timed;
  assign retry_clr = (state_d != LT_RECOVER);

  lt_timer #(.TMO_CYC(TMO_CYC)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (tmr_clr),
    .expired_o (expired)
  );

  lt_retry #(.TRIES(RECOV_TRIES)) i_retry (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (retry_clr),
    .inc_i  (retry_inc),
    .last_o (retry_last)
  );

  lt_cfg_latch #(.MAX_WIDTH(MAX_WIDTH)) i_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_cfg),
    .width_i (width_i),
    .rev_i   (lane_rev_i),
    .valid_o (width_ok),
    .width_o (width_o),
    .rev_o   (lane_rev_o)
  );

  assign state_o   = state_q;
  assign rate_o    = (state_q == LT_IDLE) ? RATE_NONE : RATE_GEN1;
  assign ts_tx_o   = (state_q == LT_POLL) || (state_q == LT_CONFIG) ||
                     (state_q == LT_RECOVER);
  assign link_up_o = (state_q == LT_ACTIVE);
endmodule

// File: rtl/lt_chk.sv
module lt_chk #(
  parameter int unsigned TMO_CYC   = 16,
  parameter int unsigned MAX_WIDTH = 32,
  localparam int unsigned WW = $clog2(MAX_WIDTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          perst_ni,
  input logic          refclk_ok_i,
  input logic          err_i,
  input logic          wake_i,
  input logic [2:0]    state_o,
  input logic [2:0]    rate_o,
  input logic          link_up_o,
  input logic [WW-1:0] width_o
);
  logic [2:0]  st_q;
  logic [15:0] stay_q, stay_cur;

  assign stay_cur = (state_o == st_q) ? stay_q + 16'd1 : 16'd0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= 3'd0;
      stay_q <= '0;
    end else begin
      st_q   <= state_o;
      stay_q <= stay_cur;
    end
  end

  a_r1_perst_forces_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !perst_ni |=> state_o == 3'd0);

  a_r2_detect_needs_refclk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_o) == 3'd0 && state_o == 3'd1) |-> $past(refclk_ok_i));

  a_r3_rate_gen1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd2 || state_o == 3'd5) |-> rate_o == 3'd1);

  a_r5_width_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(link_up_o) && $past(state_o) == 3'd3) |->
      (width_o != '0 && width_o <= WW'(MAX_WIDTH)));

  a_r6_window_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd2 || state_o == 3'd3) |-> stay_cur < 16'(TMO_CYC));

  a_r7_up_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_up_o) |-> ($past(state_o) == 3'd3 || $past(state_o) == 3'd5));

  a_r8_err_to_recover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4 && err_i && perst_ni) |=> state_o == 3'd5);

  a_r10_lowpwr_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd6 && !wake_i && perst_ni) |=> state_o == 3'd6);
endmodule

bind link_train_fsm lt_chk #(.TMO_CYC(TMO_CYC), .MAX_WIDTH(MAX_WIDTH)) i_lt_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .perst_ni    (perst_ni),
  .refclk_ok_i (refclk_ok_i),
  .err_i       (err_i),
  .wake_i      (wake_i),
  .state_o     (state_o),
  .rate_o      (rate_o),
  .link_up_o   (link_up_o),
  .width_o     (width_o)
);

// File: tb/test_link_train_fsm.sv
module test_link_train_fsm;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 16;
  localparam int TRIES = 3;
  localparam int MAXW = 32;
  localparam int WW = $clog2(MAXW + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic perst = 1'b1, refclk = 1'b1, rx = 1'b0, lock = 1'b0, align = 1'b0;
  logic [WW-1:0] width = '0;
  logic rev = 1'b0, err = 1'b0, idle = 1'b0, wake = 1'b0;
  logic [2:0] state, rate;
  logic ts, up, rev_o;
  logic [WW-1:0] width_o;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_train_fsm #(.TMO_CYC(TMO), .RECOV_TRIES(TRIES), .MAX_WIDTH(MAXW)) i_link_train_fsm (
    .clk_i(clk), .rst_ni(rst_n), .perst_ni(perst), .refclk_ok_i(refclk),
    .rx_detect_i(rx), .sym_lock_i(lock), .lane_align_i(align), .width_i(width),
    .lane_rev_i(rev), .err_i(err), .idle_req_i(idle), .wake_i(wake),
    .state_o(state), .rate_o(rate), .ts_tx_o(ts), .link_up_o(up),
    .width_o(width_o), .lane_rev_o(rev_o));

  // behavioural reference
  int m_st, m_cnt, m_tries, m_w, m_rev;
  bit m_prev, m_armed;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_tries = 0; m_w = 0; m_rev = 0; m_prev = 1; m_armed = 0;
    end else begin
      int nx;
      bit rise, again, expire, timed_now;
      rise = perst && !m_prev;
      m_prev = perst;
      nx = m_st; again = 0;
      expire = (m_cnt == TMO - 1);
      timed_now = (m_st >= 1 && m_st <= 3) || m_st == 5;
      if (!perst) begin nx = 0; m_armed = 0; end
      else if (m_st == 0) begin
        if ((rise || m_armed) && refclk) begin nx = 1; m_armed = 0; end
        else if (rise) m_armed = 1;
      end else if (m_st == 1) begin
        if (rx) nx = 2; else if (expire) again = 1;
      end else if (m_st == 2) begin
        if (lock) nx = 3; else if (expire) nx = 1;
      end else if (m_st == 3) begin
        if (align && width >= 1 && width <= MAXW) begin nx = 4; m_w = width; m_rev = rev; end
        else if (expire) nx = 1;
      end else if (m_st == 4) begin
        if (err) nx = 5; else if (idle) nx = 6;
      end else if (m_st == 5) begin
        if (lock) nx = 4;
        else if (expire) begin
          if (m_tries == TRIES - 1) nx = 1; else begin m_tries++; again = 1; end
        end
      end else if (m_st == 6) begin
        if (wake) nx = 5;
      end
      if (nx != 5) m_tries = 0;
      m_cnt = (nx != m_st || again || !timed_now) ? 0 : m_cnt + 1;
      m_st = nx;
    end
  end

  function automatic string tag_of(int s);
    case (s)
      0: return "R1"; 1: return "R3"; 2: return "R4"; 3: return "R5";
      4: return "R7"; 5: return "R9"; default: return "R10";
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({tag_of(m_st), " state"}, state, m_st);
      chk("R3 rate", rate, (m_st == 0) ? 0 : 1);
      chk("R4 ts_tx", ts, (m_st == 2 || m_st == 3 || m_st == 5) ? 1 : 0);
      chk("R7 link_up", up, (m_st == 4) ? 1 : 0);
      chk("R5 width", width_o, m_w);
      chk("R5 lane_rev", rev_o, m_rev);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog act=%0d exp=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic to_active(int w, bit r);
    rx = 1; cyc(1); rx = 0;
    lock = 1; cyc(1); lock = 0;
    align = 1; width = WW'(w); rev = r; cyc(1); align = 0;
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    chk("R1 reset state", state, 0);
    chk("R1 reset link_up", up, 0);
    chk("R1 reset ts_tx", ts, 0);
    chk("R1 reset rate", rate, 0);
    chk("R1 reset width", width_o, 0);
    cyc(5);
    chk("R2 no release edge", state, 0);
    perst = 0; cyc(2);
    refclk = 0; perst = 1; cyc(4);
    chk("R2 waits for refclk", state, 0);
    refclk = 1; cyc(1);
    chk("R2 detect entered", state, 1);
    chk("R3 gen1 rate", rate, 1);
    cyc(20);
    chk("R6 detect restarts", state, 1);
    rx = 1; cyc(1); rx = 0;
    chk("R3 detect to poll", state, 2);
    chk("R4 ts in poll", ts, 1);
    cyc(TMO - 1);
    chk("R6 poll before expiry", state, 2);
    cyc(1);
    chk("R6 poll timeout", state, 1);
    rx = 1; cyc(1); rx = 0;
    cyc(TMO - 1);
    lock = 1; cyc(1); lock = 0;
    chk("R6 lock beats expiry", state, 3);
    align = 1; width = '0; cyc(2);
    chk("R5 width 0 ignored", state, 3);
    width = WW'(40); cyc(2);
    chk("R5 width 40 ignored", state, 3);
    width = WW'(8); rev = 1; cyc(1); align = 0;
    chk("R5 active entered", state, 4);
    chk("R5 width latched", width_o, 8);
    chk("R5 rev latched", rev_o, 1);
    chk("R7 link up", up, 1);
    chk("R4 no ts in active", ts, 0);
    err = 1; idle = 1; cyc(1); err = 0; idle = 0;
    chk("R8 err beats idle", state, 5);
    chk("R7 link drops", up, 0);
    lock = 1; cyc(1); lock = 0;
    chk("R9 relock", state, 4);
    idle = 1; cyc(1); idle = 0;
    chk("R8 idle to lowpwr", state, 6);
    cyc(40);
    chk("R10 lowpwr holds", state, 6);
    wake = 1; cyc(1); wake = 0;
    chk("R10 wake to recover", state, 5);
    cyc(TMO * TRIES - 1);
    chk("R9 still retrying", state, 5);
    cyc(1);
    chk("R9 retries exhausted", state, 1);
    to_active(32, 0);
    chk("R5 width 32 accepted", width_o, 32);
    chk("R5 rev cleared", rev_o, 0);
    perst = 0; cyc(1);
    chk("R1 perst to idle", state, 0);
    chk("R1 link down", up, 0);
    perst = 1; cyc(1);
    chk("R2 same-edge start", state, 1);
    cyc(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule